// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sits between a synchronous host and a classic asynchronous DRAM that has a multiplexed address bus, a bidirectional data pin and four active-low strobes: row strobe, column strobe, write enable and output enable. The host presents one read or write at a time on a valid/ready handshake. The address is split into a row half and a column half. The upper `ROW_W` bits form the row and the lower `COL_W` bits form the column. The row goes on the DRAM address bus while the row strobe falls. The column goes on the same bus while the column strobe falls.

When the open row matches the next request, the row strobe stays low and only a new column cycle is run (page mode). A request for a different row closes the row and waits out the precharge time before the next activation. Reaching the maximum row-strobe low time also closes the row. A free-running interval timer raises a pending refresh. The refresh is served as a row-only access: the row strobe goes low with the column strobe high. Refresh rows come from a counter that steps through every row in order and wraps. Every timing value is a whole number of clock cycles set by a parameter.

The state machine has eight states. IDLE has no row open. ACT holds the row strobe low through the row-to-column delay. COL is one setup cycle with the column address and the write or output enable. CAS holds the column strobe low. CREC is the column-strobe recovery. OPEN is a page held open. PRE is precharge. REF is a refresh access. The transitions are:
- IDLE to REF when a refresh is pending, and IDLE to ACT when a request is accepted.
- ACT to COL to CAS to CREC to OPEN, each step taken as its cycle count runs out.
- OPEN to COL on a same-row request.
- OPEN to PRE on a row miss, a pending refresh or row-time exhaustion.
- PRE to ACT when a row-miss request is held, and PRE to IDLE otherwise.
- REF to PRE.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all four strobes are high (1) and the data pin is high-Z. `req_ready` is high in IDLE. The first refresh after reset uses row 0.
- R2: A request's row (address bits [ROW_W+COL_W-1:COL_W]) is on `dram_addr` while `dram_ras_n` falls. Its column (bits [COL_W-1:0]) is on `dram_addr` while `dram_cas_n` falls and stays stable while `dram_cas_n` is low. Data written to an address reads back from that address.
- R3: A write drives `dram_we_n` low and `dram_oe_n` high in the cycle before `dram_cas_n` falls and holds them through the column strobe. The controller drives the data pin during this time.
- R4: A read drives `dram_oe_n` low and `dram_we_n` high before `dram_cas_n` falls and releases the data pin. The sampled data appears on `rd_data` with `rd_valid` high for exactly one cycle. This happens T_CAS cycles after the cycle in which `dram_cas_n` went low.
- R5: A same-row request while a page is open gets another column strobe inside the same row-strobe low window. A different-row request closes the row. The row strobe is then high for at least T_RP cycles before every fall.
- R6: `dram_ras_n` is never low for more than T_RAS_MAX consecutive cycles.
- R7: A refresh keeps `dram_cas_n` and `dram_we_n` high during its row-strobe window. Refresh rows run 0, 1, 2 and so on, and wrap to 0 after 2^ROW_W - 1.
- R8: A refresh is requested every REF_INTERVAL cycles. A pending refresh is served before any new host request. A request already accepted for a row miss is completed first.
- R9: `req_ready` is high only in IDLE or OPEN with no refresh pending and the row time not exhausted. It is never high while `dram_cas_n` is low.
- R10: `dram_cas_n` is low only while `dram_ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | DATA_W | Bidirectional data |

## Verification
The collision of interest is the refresh timer expiring while a page is open and a same-row request is already waiting at the handshake. In that cycle the scheduler must close the row instead of starting another column cycle. The bench keeps requests flowing back to back across every address, first in row order and then in column order. With a refresh interval that is not a multiple of any access length, expiry lands in every state, including OPEN with a request presented. The outcome is judged through the device model. It must see refresh rows in unbroken order. No refresh window may contain a column strobe or write enable. Every read must return the value last written to its address at the expected latency.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT,
        S_COL,
        S_CAS,
        S_CREC,
        S_OPEN,
        S_PRE,
        S_REF
    } dpc_state_e;

    function automatic int dpc_max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dpc_timer.sv
module dpc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/dpc_refresh.sv
module dpc_refresh #(
    parameter int ROW_W        = 9,
    parameter int REF_INTERVAL = 290
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);

    localparam int CW = $clog2(REF_INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

    logic [CW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            if (ref_done) begin
                ref_pend <= 1'b0;
                ref_row  <= ref_row + 1'b1;
            end
            if (tick) begin
                ref_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpc_fsm.sv
module dpc_fsm
    import dpc_pkg::*;
#(
    parameter int ROW_W     = 9,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 8,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 3,
    parameter int T_RAS_MAX = 500,
    parameter int TW        = 2,
    parameter int AB_W      = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    input  logic                   ref_pend,
    input  logic [ROW_W-1:0]       ref_row,
    output logic                   ref_done,
    output logic                   tmr_load,
    output logic [TW-1:0]          tmr_val,
    input  logic                   tmr_done,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [AB_W-1:0]        addr,
    output logic                   dq_oe,
    output logic [DATA_W-1:0]      dq_out,
    input  logic [DATA_W-1:0]      dq_in,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int COLCYC    = 1 + T_CAS + T_CP;
    localparam int AGE_LIMIT = T_RAS_MAX - COLCYC - 1;
    localparam int AW        = $clog2(T_RAS_MAX + 2);

    localparam logic [TW-1:0] V_RCD = TW'(T_RCD - 1);
    localparam logic [TW-1:0] V_CAS = TW'(T_CAS - 1);
    localparam logic [TW-1:0] V_CP  = TW'(T_CP - 1);
    localparam logic [TW-1:0] V_RP  = TW'(T_RP - 1);
    localparam logic [TW-1:0] V_REF = TW'(T_REF_RAS - 1);

    dpc_state_e state, nxt;

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wd_q;
    logic              has_req;
    logic [AW-1:0]     ras_age;
    logic              age_close;
    logic              accept;
    logic              row_hit;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;

    assign req_row   = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col   = req_addr[COL_W-1:0];
    assign row_hit   = (req_row == row_q);
    assign age_close = (ras_age >= AW'(AGE_LIMIT));
    assign accept    = req_valid && req_ready;
    assign dq_out    = wd_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_done = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ref_pend) begin
                    nxt      = S_REF;
                    tmr_load = 1'b1;
                    tmr_val  = V_REF;
                end else if (req_valid) begin
                    nxt      = S_ACT;
                    tmr_load = 1'b1;
                    tmr_val  = V_RCD;
                end
            end
            S_ACT: begin
                if (tmr_done) nxt = S_COL;
            end
            S_COL: begin
                nxt      = S_CAS;
                tmr_load = 1'b1;
                tmr_val  = V_CAS;
            end
            S_CAS: begin
                if (tmr_done) begin
                    nxt      = S_CREC;
                    tmr_load = 1'b1;
                    tmr_val  = V_CP;
                end
            end
            S_CREC: begin
                if (tmr_done) nxt = S_OPEN;
            end
            S_OPEN: begin
                if (ref_pend || age_close) begin
                    nxt      = S_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = V_RP;
                end else if (req_valid) begin
                    if (row_hit) begin
                        nxt = S_COL;
                    end else begin
                        nxt      = S_PRE;
                        tmr_load = 1'b1;
                        tmr_val  = V_RP;
                    end
                end
            end
            S_PRE: begin
                if (tmr_done) begin
                    if (has_req) begin
                        nxt      = S_ACT;
                        tmr_load = 1'b1;
                        tmr_val  = V_RCD;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            S_REF: begin
                if (tmr_done) begin
                    nxt      = S_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = V_RP;
                    ref_done = 1'b1;
                end
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        addr      = AB_W'(row_q);
        req_ready = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready = !ref_pend;
            end
            S_ACT: begin
                ras_n = 1'b0;
            end
            S_COL, S_CAS: begin
                ras_n = 1'b0;
                cas_n = (state != S_CAS);
                addr  = AB_W'(col_q);
                we_n  = !wr_q;
                oe_n  = wr_q;
                dq_oe = wr_q;
            end
            S_CREC: begin
                ras_n = 1'b0;
                addr  = AB_W'(col_q);
            end
            S_OPEN: begin
                ras_n     = 1'b0;
                addr      = AB_W'(col_q);
                req_ready = !ref_pend && !age_close;
            end
            S_PRE: begin
            end
            S_REF: begin
                ras_n = 1'b0;
                addr  = AB_W'(ref_row);
            end
        endcase
    end

    // request capture, row age and read return
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            col_q    <= '0;
            wr_q     <= 1'b0;
            wd_q     <= '0;
            has_req  <= 1'b0;
            ras_age  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                row_q <= req_row;
                col_q <= req_col;
                wr_q  <= req_write;
                wd_q  <= req_wdata;
            end
            if (state == S_OPEN && accept && !row_hit) begin
                has_req <= 1'b1;
            end else if (state == S_ACT) begin
                has_req <= 1'b0;
            end
            if (nxt == S_ACT && state != S_ACT) begin
                ras_age <= '0;
            end else if (!ras_n && ras_age != {AW{1'b1}}) begin
                ras_age <= ras_age + 1'b1;
            end
            if (state == S_CAS && tmr_done && !wr_q) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
            end
        end
    end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 1,
    parameter int T_RP         = 3,
    parameter int T_REF_RAS    = 3,
    parameter int T_RAS_MAX    = 500,
    parameter int REF_INTERVAL = 290
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ROW_W+COL_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic                           req_ready,
    output logic                           rd_valid,
    output logic [DATA_W-1:0]              rd_data,
    output logic [dpc_max2(ROW_W,COL_W)-1:0] dram_addr,
    output logic                           dram_ras_n,
    output logic                           dram_cas_n,
    output logic                           dram_we_n,
    output logic                           dram_oe_n,
    inout  wire  [DATA_W-1:0]              dram_dq
);

    localparam int AB_W = dpc_max2(ROW_W, COL_W);
    localparam int TMAX = dpc_max2(dpc_max2(dpc_max2(T_RCD, T_CAS), dpc_max2(T_CP, T_RP)), T_REF_RAS);
    localparam int TW   = $clog2(TMAX + 1);

    logic             ref_pend;
    logic             ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             dq_oe;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in;

    assign dram_dq = dq_oe ? dq_out : {DATA_W{1'bz}};
    assign dq_in   = dram_dq;

    dpc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dpc_refresh #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .ref_done (ref_done),
        .ref_pend (ref_pend),
        .ref_row  (ref_row)
    );

    dpc_fsm #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DATA_W    (DATA_W),
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_CP      (T_CP),
        .T_RP      (T_RP),
        .T_REF_RAS (T_REF_RAS),
        .T_RAS_MAX (T_RAS_MAX),
        .TW        (TW),
        .AB_W      (AB_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .ref_pend  (ref_pend),
        .ref_row   (ref_row),
        .ref_done  (ref_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_done  (tmr_done),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n),
        .oe_n      (dram_oe_n),
        .addr      (dram_addr),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out),
        .dq_in     (dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int T_RAS_MAX = 500,
    parameter int AB_W      = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            oe_n,
    input logic [AB_W-1:0] addr,
    input logic            rd_valid,
    input logic            req_ready
);

    int ras_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo <= 0;
        end else begin
            ras_lo <= ras_n ? 0 : ras_lo + 1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (ras_n && cas_n && we_n && oe_n)); // R1
    AST_COL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!cas_n && $past(!cas_n)) |-> $stable(addr)); // R2
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst) ($fell(cas_n) && !we_n) |-> ($past(!we_n) && oe_n)); // R3
    AST_EARLY_READ: assert property (@(posedge clk) disable iff (rst) ($fell(cas_n) && !oe_n) |-> ($past(!oe_n) && we_n)); // R4
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid); // R4
    AST_RAS_MAX_LOW: assert property (@(posedge clk) disable iff (rst) ras_lo <= T_RAS_MAX); // R6
    AST_READY_NOT_IN_CAS: assert property (@(posedge clk) disable iff (rst) req_ready |-> cas_n); // R9
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R10
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!we_n && !oe_n)); // R3

endmodule

bind dram_page_ctrl dpc_checker #(.T_RAS_MAX(T_RAS_MAX), .AB_W(AB_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .rd_valid  (rd_valid),
    .req_ready (req_ready)
);

// File: tb/dram_page_ctrl_tb.sv
`timescale 1ns/1ps
module dram_page_ctrl_tb;

    localparam int RW     = 3;
    localparam int CWD    = 3;
    localparam int T_RCD  = 2;
    localparam int T_CAS  = 2;
    localparam int T_CP   = 1;
    localparam int T_RP   = 2;
    localparam int T_REFR = 3;
    localparam int T_RMAX = 20;
    localparam int REF_I  = 97;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [2:0] dram_addr;
    logic       dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    wire  [7:0] dram_dq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_page_ctrl #(
        .ROW_W(RW), .COL_W(CWD), .DATA_W(8), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_CP(T_CP), .T_RP(T_RP), .T_REF_RAS(T_REFR), .T_RAS_MAX(T_RMAX),
        .REF_INTERVAL(REF_I)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq(dram_dq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural device model, sampled mid-cycle
    logic [7:0] mem [64];
    logic [2:0] m_row = '0, m_col = '0;
    logic       m_drive = 1'b0;
    assign dram_dq = m_drive ? mem[{m_row, m_col}] : 8'bz;

    bit prev_ras = 1, prev_cas = 1, prev_we_lo = 0, prev_oe_lo = 0;
    int hi_len = 100, win_len = 0, win_cas = 0, max_len = 0, multi = 0;
    bit win_we = 0;
    int viol_rp = 0, viol_ew = 0, viol_er = 0, viol_cas = 0, viol_rdy = 0;
    int ref_count = 0, rd_count = 0, cas_fall_cyc = 0;
    logic [2:0] exp_ref = '0;
    logic [7:0] exp_q [$];

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ras && !dram_ras_n) begin
                m_row   = dram_addr;
                win_cas = 0;
                win_len = 0;
                win_we  = 0;
                if (hi_len < T_RP) viol_rp++;
            end
            if (dram_ras_n) begin
                hi_len++;
            end else begin
                hi_len = 0;
                win_len++;
                if (!dram_we_n) win_we = 1;
            end
            if (prev_cas && !dram_cas_n) begin
                m_col = dram_addr;
                win_cas++;
                if (dram_ras_n) viol_cas++;
                if (!dram_we_n) begin
                    if (!prev_we_lo || !dram_oe_n) viol_ew++;
                    mem[{m_row, dram_addr}] = dram_dq;
                end else begin
                    if (!prev_oe_lo || dram_oe_n) viol_er++;
                    m_drive      = 1'b1;
                    cas_fall_cyc = cyc;
                end
            end
            if (dram_cas_n) m_drive = 1'b0;
            if (!prev_ras && dram_ras_n) begin
                if (win_cas == 0) begin
                    chk(m_row == exp_ref && !win_we, "R7 refresh row", m_row, exp_ref);
                    exp_ref++;
                    ref_count++;
                end else begin
                    if (win_cas > 1) multi++;
                    if (win_len > max_len) max_len = win_len;
                end
            end
            if (req_ready && !dram_cas_n) viol_rdy++;
            if (rd_valid) begin
                rd_count++;
                chk(cyc - cas_fall_cyc == T_CAS, "R4 read latency", cyc - cas_fall_cyc, T_CAS);
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected rd_valid", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R2 read data", rd_data, e);
                end
            end
        end
        prev_ras   = dram_ras_n;
        prev_cas   = dram_cas_n;
        prev_we_lo = !dram_we_n;
        prev_oe_lo = !dram_oe_n;
    end

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] pat2(input int a);
        return 8'(((a * 91) & 255) ^ 8'h5A);
    endfunction

    task automatic issue(input logic wr, input logic [5:0] a, input logic [7:0] d);
        if (!wr) exp_q.push_back(d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wr ? d : 8'h00;
        forever begin
            if (req_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int multi_rowmaj;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(dram_dq === 8'bz, "R1 data high-Z in reset", dram_dq, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes after reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);

        // row-major sweep: page hits inside each row
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                issue(1'b1, 6'(r * 8 + c), pat1(r * 8 + c));
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                issue(1'b0, 6'(r * 8 + c), pat1(r * 8 + c));
        repeat (40) @(negedge clk);
        multi_rowmaj = multi;
        chk(multi_rowmaj > 0, "R5 page reuse in row order", multi_rowmaj, 1);
        multi = 0;

        // column-major sweep: every access misses the open row
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                issue(1'b1, 6'(r * 8 + c), pat2(r * 8 + c));
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 8; r++)
                issue(1'b0, 6'(r * 8 + c), pat2(r * 8 + c));
        repeat (40) @(negedge clk);

        chk(multi == 0, "R5 row miss closes row", multi, 0);
        chk(viol_rp == 0, "R5 precharge time", viol_rp, 0);
        chk(max_len <= T_RMAX, "R6 row strobe low time", max_len, T_RMAX);
        chk(viol_ew == 0, "R3 early write order", viol_ew, 0);
        chk(viol_er == 0, "R4 early read order", viol_er, 0);
        chk(viol_cas == 0, "R10 column strobe inside row strobe", viol_cas, 0);
        chk(viol_rdy == 0, "R9 ready during column strobe", viol_rdy, 0);
        chk(ref_count > 8, "R7 refresh counter wrapped", ref_count, 9);
        chk(ref_count >= cyc / REF_I - 1, "R8 refresh rate", ref_count, cyc / REF_I - 1);
        chk(rd_count == 128, "R4 read return count", rd_count, 128);
        chk(exp_q.size() == 0, "R4 outstanding reads", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule